// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block takes configuration words that arrive on three slow, asynchronous wires (a serial clock, a serial data line and a load strobe) and turns them into four parallel registers inside the system clock domain. The three wires are first synchronized to the system clock. Each rising edge of the serial clock then shifts one data bit into a 21-bit frame register, the first bit sent ending up as the most significant bit.

A rising edge on the load strobe copies the whole frame into one of four destination registers. The two lowest bits of the frame name the destination. The chosen register takes the frame and raises its own update pulse for one system clock cycle, so that downstream logic knows a new value has arrived. Only the destination bits of the frame are decoded here; the meaning of the other bits belongs to whatever consumes the registers.

There is no handshake on either side. The serial wires cannot be held back, and the registers are always readable and always hold their last loaded value, so there is no back-pressure to apply. A consumer that needs to act on a new value watches the update pulse of that register.

Top module: `ser_cfg_loader`

## Requirements
- R1: While reset is asserted and after it is released, all four registers read zero and no update pulse is raised until a load strobe arrives.
- R2: One data bit is sampled per rising edge of the serial clock, and a loaded register holds the last 21 bits with the first bit sent in bit 20 and the last bit sent in bit 0.
- R3: Frame bits [1:0] choose the destination: 00 writes register 0, 01 writes register 1, 10 writes register 2 and 11 writes register 3; the other three registers keep their contents.
- R4: A register is written only on a rising edge of the load strobe; serial clocks sent while the strobe is low or held high change no register and raise no pulse.
- R5: When more than 21 serial clock edges come before a strobe, only the last 21 bits sent are kept.
- R6: Each strobe raises exactly one update pulse, one system clock cycle wide, on the output of the written register only; at most one pulse is high at any time.
- R7: The written register stores the full 21-bit frame, destination bits included.
- R8: Changes on the data line while the serial clock does not rise, including on its falling edges, leave the frame register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_data | input | 1 | Serial data, sampled on ser_clk rising edge |
| ser_le | input | 1 | Load strobe, rising edge transfers the frame |
| latch_q | output | 84 | Four 21-bit registers, register i at bits [21*i+20 : 21*i] |
| upd_pulse | output | 4 | One-cycle update pulse per register, bit i for register i |

## Verification
The hardest state to reach from the ports is a frame register whose contents differ from what the last strobe copied out, since that register is never visible directly. The stimulus brings it out by loading a known word, then wiggling the data line without clock edges, shifting bits with the strobe high, or sending more than 21 bits, and finally issuing a single fresh strobe so that the register's hidden contents appear in one destination. Comparing every destination and every pulse count after each scenario shows both the routed value and that no other register moved.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
  // Default frame geometry
  localparam int unsigned FRAME_W_DEF = 21;
  localparam int unsigned ADDR_W_DEF  = 2;
  localparam int unsigned SYNC_DEF    = 2;

  // Lane positions of the synchronized serial pins
  localparam int unsigned LANE_DATA = 0;
  localparam int unsigned LANE_CLK  = 1;
  localparam int unsigned LANE_LE   = 2;
  localparam int unsigned NUM_LANES = 3;
endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ser_cfg_edge.sv
module ser_cfg_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= level;
  end

  assign rise = level & ~prev;
endmodule

// File: rtl/ser_cfg_shifter.sv
module ser_cfg_shifter #(
  parameter int unsigned FRAME_W = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame <= '0;
    else if (shift_en) frame <= {frame[FRAME_W-2:0], bit_in};
  end
endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank #(
  parameter int unsigned FRAME_W = 21,
  parameter int unsigned ADDR_W  = 2,
  localparam int unsigned NUM_LATCH = 1 << ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [FRAME_W-1:0]            frame,
  output logic [NUM_LATCH*FRAME_W-1:0]  latch_q,
  output logic [NUM_LATCH-1:0]          upd
);
  logic [ADDR_W-1:0]    dest;
  logic [NUM_LATCH-1:0] sel;

  assign dest = frame[ADDR_W-1:0];

  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_latch
    logic [FRAME_W-1:0] store;

    assign sel[i] = load && (dest == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store  <= '0;
        upd[i] <= 1'b0;
      end else begin
        upd[i] <= sel[i];
        if (sel[i]) store <= frame;
      end
    end

    assign latch_q[i*FRAME_W +: FRAME_W] = store;
  end
endmodule

// File: rtl/ser_cfg_loader.sv
module ser_cfg_loader
  import ser_cfg_pkg::*;
#(
  parameter int unsigned FRAME_W = FRAME_W_DEF,
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned STAGES  = SYNC_DEF,
  localparam int unsigned NUM_LATCH = 1 << ADDR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ser_clk,
  input  logic                         ser_data,
  input  logic                         ser_le,
  output logic [NUM_LATCH*FRAME_W-1:0] latch_q,
  output logic [NUM_LATCH-1:0]         upd_pulse
);
  logic [NUM_LANES-1:0] pins_raw;
  logic [NUM_LANES-1:0] pins_sync;
  logic [1:0]           edges;
  logic [FRAME_W-1:0]   frame;

  always_comb begin
    pins_raw            = '0;
    pins_raw[LANE_DATA] = ser_data;
    pins_raw[LANE_CLK]  = ser_clk;
    pins_raw[LANE_LE]   = ser_le;
  end

  ser_cfg_sync #(.WIDTH(NUM_LANES), .STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pins_raw),
    .sync_out (pins_sync)
  );

  // edges[0]: serial clock rise, edges[1]: strobe rise
  ser_cfg_edge #(.WIDTH(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level ({pins_sync[LANE_LE], pins_sync[LANE_CLK]}),
    .rise  (edges)
  );

  ser_cfg_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (edges[0]),
    .bit_in   (pins_sync[LANE_DATA]),
    .frame    (frame)
  );

  // A strobe in the same cycle as a shift copies the pre-shift frame.
  ser_cfg_bank #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (edges[1]),
    .frame   (frame),
    .latch_q (latch_q),
    .upd     (upd_pulse)
  );
endmodule

// File: rtl/ser_cfg_loader_chk.sv
module ser_cfg_loader_chk #(
  parameter int unsigned FRAME_W   = 21,
  parameter int unsigned NUM_LATCH = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_LATCH*FRAME_W-1:0] latch_q,
  input logic [NUM_LATCH-1:0]         upd
);
  localparam int unsigned AW = $clog2(NUM_LATCH);

  // R1: reset clears every register and pulse
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (latch_q == '0 && upd == '0));

  // R6: never two pulses together
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd));

  // R6: a pulse lasts one cycle
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (upd != '0) |=> (upd == '0));

  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_chk
    // R4: a register changes only together with its own pulse
    a_r4_change_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q[i*FRAME_W +: FRAME_W] != $past(latch_q[i*FRAME_W +: FRAME_W])) |-> upd[i]);

    // R3: a pulsed register holds a frame addressed to it
    a_r3_dest_match: assert property (@(posedge clk) disable iff (!rst_n)
      upd[i] |-> (latch_q[i*FRAME_W +: AW] == AW'(i)));
  end
endmodule

bind ser_cfg_loader ser_cfg_loader_chk #(
  .FRAME_W   (FRAME_W),
  .NUM_LATCH (NUM_LATCH)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .latch_q (latch_q),
  .upd     (upd_pulse)
);

// File: tb/ser_cfg_loader_tb.sv
module ser_cfg_loader_tb;
  localparam int FW = 21;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_data = 1'b0;
  logic ser_le = 1'b0;
  logic [NL*FW-1:0] latch_q;
  logic [NL-1:0]    upd_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [FW-1:0] exp_q [NL];
  int pcnt [NL];
  int exp_cnt [NL];
  int wide = 0;
  logic [NL-1:0] upd_prev = '0;

  always #2 clk = ~clk;

  ser_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .latch_q(latch_q), .upd_pulse(upd_pulse)
  );

  // Pulse monitor sampled away from the active edge
  always @(negedge clk) begin
    for (int i = 0; i < NL; i++) begin
      if (upd_pulse[i]) pcnt[i]++;
      if (upd_pulse[i] && upd_prev[i]) wide++;
    end
    upd_prev <= upd_pulse;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [63:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i];
      wait_cyc(3);
      ser_clk = 1'b1;
      wait_cyc(3);
      ser_clk = 1'b0;
      wait_cyc(3);
    end
  endtask

  task automatic strobe();
    ser_le = 1'b1;
    wait_cyc(4);
    ser_le = 1'b0;
    wait_cyc(8);
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NL; i++) begin
      chk($sformatf("%s reg%0d", tag, i), 64'(latch_q[i*FW +: FW]), 64'(exp_q[i]));
      chk($sformatf("%s R6 pulses reg%0d", tag, i), 64'(pcnt[i]), 64'(exp_cnt[i]));
    end
  endtask

  task automatic load_word(input logic [FW-1:0] w);
    send_bits(64'(w), FW);
    strobe();
    exp_q[w[1:0]] = w;
    exp_cnt[w[1:0]]++;
  endtask

  task automatic t_reset();
    // R1
    check_all("R1 reset");
  endtask

  task automatic t_route();
    // R2 R3 R7: one word per destination, MSB first
    load_word(21'h1A5B3C);
    check_all("R2 R3 R7 dest0");
    load_word(21'h0F0F0D);
    check_all("R3 dest1");
    load_word(21'h15555E);
    check_all("R3 dest2");
    load_word(21'h12345B);
    check_all("R3 R7 dest3");
    load_word(21'h100001);
    check_all("R2 R3 dest1 overwrite");
  endtask

  task automatic t_overlong();
    // R5: four extra leading bits are discarded
    send_bits(64'hF, 4);
    load_word(21'h0ABCD6);
    check_all("R5 overlong");
  endtask

  task automatic t_no_strobe();
    // R4: shifting with strobe low changes nothing
    send_bits(64'h1FFFFC, FW);
    wait_cyc(8);
    check_all("R4 strobe low");
    // R4: shifting with strobe held high changes nothing
    ser_le = 1'b1;
    wait_cyc(8);
    exp_q[0] = 21'h1FFFFC;
    exp_cnt[0]++;
    send_bits(64'h0000F3, FW);
    wait_cyc(8);
    check_all("R4 strobe high");
    ser_le = 1'b0;
    wait_cyc(8);
    check_all("R4 strobe fall");
    // the frame shifted under a high strobe loads on the next rise
    strobe();
    exp_q[3] = 21'h0000F3;
    exp_cnt[3]++;
    check_all("R4 later rise");
  endtask

  task automatic t_data_only();
    // R8: data toggles without clock rises leave the frame intact
    load_word(21'h0C3A52);
    for (int k = 0; k < 10; k++) begin
      ser_data = ~ser_data;
      wait_cyc(3);
    end
    ser_clk = 1'b1;   // clock already high pattern: only falling edges follow
    ser_clk = 1'b0;
    wait_cyc(4);
    strobe();
    exp_cnt[2]++;
    check_all("R8 data only");
    chk("R6 pulse width", 64'(wide), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin
      exp_q[i] = '0;
      pcnt[i] = 0;
      exp_cnt[i] = 0;
    end
    wait_cyc(5);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_route();
    t_overlong();
    t_no_strobe();
    t_data_only();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule